// File: doc/BRIEF.md
# Bidirectional LCD Common Scan Register

This block walks a single scan token across the common (row) select lines of a passive-matrix LCD. A chain of stages, one per common line, advances by one position on each qualifying edge of an external shift clock. That clock is sampled in the system clock domain. A phase input picks whether the rising or the falling edge of the shift clock qualifies, and a direction input picks which end of the chain the token enters at. Every stage drives one logic-level select flag. Level translation to the LCD drive voltages is outside the block.

Two data pins, A and B, each appear as an input, an output and an output-enable, which together model a tri-state pad. A master part takes its token from a frame pulse supplied by the timing logic and drives both pins. A slave part takes its token from whichever pin is the entry end and drives only the exit end, so it can continue a scan from a master. Cascading a master and a slave in this way gives 96- or 128-line scans. The 48- and 64-line scans need only one part.

A small state machine tracks the sampled shift-clock level. Its states are LVL_UNKNOWN (entered at reset, level not yet seen), LVL_LOW and LVL_HIGH. Its transitions are SEE_LOW (UNKNOWN to LOW), SEE_HIGH (UNKNOWN to HIGH), RISE (LOW to HIGH) and FALL (HIGH to LOW). A shift request is registered on RISE when the phase input is 0 and on FALL when the phase input is 1. The SEE_LOW and SEE_HIGH transitions never request a shift. The chain moves on the clock edge after the request.

Top module: `lcd_com_scan`

## Requirements
- R1: A synchronous active-low reset clears every stage, so `com_o` reads all zeros on the cycle after reset is sampled low. The level tracker returns to LVL_UNKNOWN, so the first shift-clock level seen after reset causes no shift.
- R2: With `dir_i`=0 the serial input enters stage 0 (`com_o[0]`, line C1), and each shift moves stage i to stage i+1.
- R3: With `dir_i`=1 the serial input enters stage 63 (`com_o[63]`, line C64), and each shift moves stage i to stage i-1.
- R4: With `phase_i`=0 only a low-to-high change of `cl2_i` shifts the chain. With `phase_i`=1 only a high-to-low change does. A change in the other direction leaves `com_o` unchanged.
- R5: With `master_i`=1 both `pa_oe` and `pb_oe` are 1. The exit pin (B when `dir_i`=0, A when `dir_i`=1) carries the last stage (`com_o[63]` or `com_o[0]` respectively), and the entry pin carries `frm_i`.
- R6: With `master_i`=0 the entry pin (A when `dir_i`=0, B when `dir_i`=1) has its enable at 0 and output at 0. Its input is the serial input. The exit pin has its enable at 1 and carries the last stage.
- R7: With `master_i`=1 the serial input is `frm_i`, and the values on `pa_i` and `pb_i` have no effect on `com_o`.
- R8: `com_o[i]` is the content of stage i. While the chain holds one token, at most one bit is set.
- R9: The chain updates two system clock edges after the edge that first samples a qualifying `cl2_i` change: one edge registers the shift request and the next edge moves the chain. Without a shift request, `com_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_i | input | 1 | 1 = master (token from `frm_i`), 0 = slave (token from a pin) |
| dir_i | input | 1 | 0 = enter at A, exit at B; 1 = enter at B, exit at A |
| phase_i | input | 1 | 0 = shift on rising shift-clock edge, 1 = on falling edge |
| cl2_i | input | 1 | Shift clock, sampled by `clk` |
| frm_i | input | 1 | Frame token pulse used in master mode |
| pa_i | input | 1 | Pad A input value |
| pa_o | output | 1 | Pad A output value |
| pa_oe | output | 1 | Pad A output enable |
| pb_i | input | 1 | Pad B input value |
| pb_o | output | 1 | Pad B output value |
| pb_oe | output | 1 | Pad B output enable |
| com_o | output | 64 | Common select flags, bit i = line C(i+1) |

## Verification
The hardest situation to reach is a change of phase, direction or mode while the shift clock sits at a level. Such a change must not count as an edge, and the pins must swap roles without the token being lost or duplicated. The stimulus changes these selects at random between shift-clock changes and mixes in same-level "toggles" and edges of the wrong polarity. It drives noise on the pin that should be ignored. A directed 64-shift walk brings the token out of the exit pin in each direction, and a reset in the middle of a run is also applied.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [1:0] {
        LVL_UNKNOWN = 2'd0,
        LVL_LOW     = 2'd1,
        LVL_HIGH    = 2'd2
    } lvl_state_e;
endpackage

// File: rtl/lcd_cl2_track.sv
module lcd_cl2_track
    import lcd_scan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cl2_i,
    input  logic phase_i,
    output logic shift_o
);
    lvl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_UNKNOWN;
        else        state_q <= state_d;
    end

    // transitions: SEE_LOW, SEE_HIGH, RISE, FALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_UNKNOWN: state_d = cl2_i ? LVL_HIGH : LVL_LOW;
            LVL_LOW:     if (cl2_i)  state_d = LVL_HIGH;
            LVL_HIGH:    if (!cl2_i) state_d = LVL_LOW;
            default:     state_d = LVL_UNKNOWN;
        endcase
    end

    // registered shift request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_o <= 1'b0;
        end else begin
            unique case (state_q)
                LVL_LOW:  shift_o <= cl2_i & ~phase_i;
                LVL_HIGH: shift_o <= ~cl2_i & phase_i;
                default:  shift_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/lcd_scan_chain.sv
module lcd_scan_chain #(
    parameter int STAGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              dir_i,
    input  logic              sin_i,
    output logic [STAGES-1:0] q_o,
    output logic              sout_o
);
    logic [STAGES-1:0] q_r;
    logic [STAGES-1:0] fwd_src;
    logic [STAGES-1:0] bwd_src;

    for (genvar g = 0; g < STAGES; g++) begin : g_src
        if (g == 0) begin : g_first
            assign fwd_src[g] = sin_i;
        end else begin : g_mid_f
            assign fwd_src[g] = q_r[g-1];
        end
        if (g == STAGES - 1) begin : g_last
            assign bwd_src[g] = sin_i;
        end else begin : g_mid_b
            assign bwd_src[g] = q_r[g+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       q_r <= '0;
        else if (shift_i) q_r <= dir_i ? bwd_src : fwd_src;
    end

    assign q_o    = q_r;
    assign sout_o = dir_i ? q_r[0] : q_r[STAGES-1];
endmodule

// File: rtl/lcd_pin_route.sv
module lcd_pin_route (
    input  logic master_i,
    input  logic dir_i,
    input  logic frm_i,
    input  logic sout_i,
    input  logic pa_i,
    input  logic pb_i,
    output logic sin_o,
    output logic pa_o,
    output logic pa_oe,
    output logic pb_o,
    output logic pb_oe
);
    logic entry_o;
    logic entry_oe;

    always_comb begin
        sin_o    = master_i ? frm_i : (dir_i ? pb_i : pa_i);
        entry_oe = master_i;
        entry_o  = master_i & frm_i;
        if (dir_i) begin
            pb_o  = entry_o;
            pb_oe = entry_oe;
            pa_o  = sout_i;
            pa_oe = 1'b1;
        end else begin
            pa_o  = entry_o;
            pa_oe = entry_oe;
            pb_o  = sout_i;
            pb_oe = 1'b1;
        end
    end
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
    parameter int STAGES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_i,
    input  logic              dir_i,
    input  logic              phase_i,
    input  logic              cl2_i,
    input  logic              frm_i,
    input  logic              pa_i,
    output logic              pa_o,
    output logic              pa_oe,
    input  logic              pb_i,
    output logic              pb_o,
    output logic              pb_oe,
    output logic [STAGES-1:0] com_o
);
    logic shift_w;
    logic sin_w;
    logic sout_w;

    lcd_cl2_track u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .cl2_i   (cl2_i),
        .phase_i (phase_i),
        .shift_o (shift_w)
    );

    lcd_scan_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_w),
        .dir_i   (dir_i),
        .sin_i   (sin_w),
        .q_o     (com_o),
        .sout_o  (sout_w)
    );

    lcd_pin_route u_route (
        .master_i (master_i),
        .dir_i    (dir_i),
        .frm_i    (frm_i),
        .sout_i   (sout_w),
        .pa_i     (pa_i),
        .pb_i     (pb_i),
        .sin_o    (sin_w),
        .pa_o     (pa_o),
        .pa_oe    (pa_oe),
        .pb_o     (pb_o),
        .pb_oe    (pb_oe)
    );
endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
    parameter int STAGES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              master_i,
    input logic              dir_i,
    input logic              shift,
    input logic              sin,
    input logic              pa_oe,
    input logic              pb_oe,
    input logic [STAGES-1:0] com_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (com_o == '0)); // R1

    AST_WALK_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !dir_i) |=> (com_o[STAGES-1:1] == $past(com_o[STAGES-2:0])
                               && com_o[0] == $past(sin))); // R2

    AST_WALK_BWD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && dir_i) |=> (com_o[STAGES-2:0] == $past(com_o[STAGES-1:1])
                              && com_o[STAGES-1] == $past(sin))); // R3

    AST_MASTER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        master_i |-> (pa_oe && pb_oe)); // R5

    AST_SLAVE_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> (pa_oe == dir_i && pb_oe == !dir_i)); // R6

    AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(com_o)); // R9
endmodule

bind lcd_com_scan lcd_com_scan_chk #(.STAGES(STAGES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_i (master_i),
    .dir_i    (dir_i),
    .shift    (shift_w),
    .sin      (sin_w),
    .pa_oe    (pa_oe),
    .pb_oe    (pb_oe),
    .com_o    (com_o)
);

// File: tb/lcd_com_scan_tb_top.sv
`timescale 1ns/1ps
module lcd_com_scan_tb_top;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_i = 1'b1, dir_i = 1'b0, phase_i = 1'b0;
    logic cl2_i = 1'b0, frm_i = 1'b0, pa_i = 1'b0, pb_i = 1'b0;
    logic pa_o, pa_oe, pb_o, pb_oe;
    logic [N-1:0] com_o;

    logic [N-1:0] mdl;
    logic cl2_prev;
    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lcd_com_scan #(.STAGES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_i(master_i), .dir_i(dir_i),
        .phase_i(phase_i), .cl2_i(cl2_i), .frm_i(frm_i),
        .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe), .com_o(com_o)
    );

    function automatic logic [N-1:0] shifted(input logic [N-1:0] v, input logic d, input logic s);
        return d ? {s, v[N-1:1]} : {v[N-2:0], s};
    endfunction

    function automatic logic [3:0] pins_exp(input logic [N-1:0] v, input logic m,
                                            input logic d, input logic f);
        logic last, en_o, en_oe;
        last  = d ? v[0] : v[N-1];
        en_o  = m & f;
        en_oe = m;
        // {pa_o, pa_oe, pb_o, pb_oe}
        return d ? {last, 1'b1, en_o, en_oe} : {en_o, en_oe, last, 1'b1};
    endfunction

    task automatic check_com(input string tag);
        n_run++;
        if (com_o !== mdl) begin
            n_fail++;
            $display("FAIL %s com_o act=%h exp=%h", tag, com_o, mdl);
        end
    endtask

    task automatic check_pins(input string tag);
        logic [3:0] e;
        e = pins_exp(mdl, master_i, dir_i, frm_i);
        n_run++;
        if ({pa_o, pa_oe, pb_o, pb_oe} !== e) begin
            n_fail++;
            $display("FAIL %s pins act=%b exp=%b", tag, {pa_o, pa_oe, pb_o, pb_oe}, e);
        end
    endtask

    // drive one shift-clock level with serial data d, then check
    task automatic step(input logic lvl, input logic d);
        logic qual, sin;
        string tag;
        @(negedge clk);
        if (master_i) begin
            frm_i = d;
            pa_i = ~d; pb_i = ~d;          // noise that must be ignored (R7)
        end else begin
            frm_i = $urandom_range(0, 1);
            if (dir_i) begin pb_i = d; pa_i = $urandom_range(0, 1); end
            else       begin pa_i = d; pb_i = $urandom_range(0, 1); end
        end
        cl2_i = lvl;
        qual = (lvl != cl2_prev) && (lvl ? !phase_i : phase_i);
        sin  = master_i ? frm_i : (dir_i ? pb_i : pa_i);
        repeat (3) @(negedge clk);
        if (qual) mdl = shifted(mdl, dir_i, sin);
        cl2_prev = lvl;
        if (!qual)         tag = "R4 no shift on other edge/level";
        else if (master_i) tag = dir_i ? "R3 R7 backward master" : "R2 R7 forward master";
        else               tag = dir_i ? "R3 R9 backward slave" : "R2 R9 forward slave";
        check_com(tag);
        check_pins(master_i ? "R5 master pins" : "R6 slave pins");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cl2_i = 1'b0;
        repeat (2) @(negedge clk);
        mdl = '0;
        check_com("R1 reset clears");
        rst_n = 1'b1;
        cl2_prev = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        mdl = '0;
        cl2_prev = 1'b0;
        repeat (3) @(negedge clk);
        do_reset();
        check_pins("R5 master pins after reset");

        // R1: first level after reset is high, no shift must occur
        @(negedge clk); rst_n = 1'b0; cl2_i = 1'b1; frm_i = 1'b1;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        mdl = '0; cl2_prev = 1'b1;
        check_com("R1 first level after reset no shift");
        frm_i = 1'b0;

        // directed: forward walk, token exits pin B (R2, R5, R8)
        master_i = 1'b1; dir_i = 1'b0; phase_i = 1'b0;
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        for (int k = 0; k < N; k++) begin
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
            n_run++;
            if ($countones(com_o) > 1) begin
                n_fail++;
                $display("FAIL R8 onehot act=%h exp=<=1 bit", com_o);
            end
        end

        // directed: backward walk on falling edges in slave mode (R3, R4, R6)
        do_reset();
        master_i = 1'b0; dir_i = 1'b1; phase_i = 1'b1;
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        for (int k = 0; k < N; k++) begin
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
        end

        // random mixture
        for (int k = 0; k < 600; k++) begin
            int r;
            r = $urandom_range(0, 15);
            if (r == 0) master_i = ~master_i;
            if (r == 1) dir_i    = ~dir_i;
            if (r == 2) phase_i  = ~phase_i;
            if (r == 3 && k % 7 == 0) do_reset();
            step(($urandom_range(0, 3) == 0) ? cl2_prev : ~cl2_prev,
                 ($urandom_range(0, 9) == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule